// File: doc/BRIEF.md
# SPI Flash Write-Protection Command Unit

This block sits on the target side of a serial-flash SPI port and owns the small set of state that decides whether the memory may be altered. It decodes four single-byte write-type opcodes as they arrive: latch set, latch clear, status arm and status write. It keeps a write-enable latch, an auto-increment flag, two block-protect bits and a protect-lock bit. Every effect is committed on the rising edge of the chip select that closes the frame, never while the frame is still open.

The SPI pins are oversampled by a fast system clock through synchronisers, so the unit works as an ordinary synchronous block inside the chip. Bits are taken MSB first on SCK rising edges, which covers both SPI mode 0 and mode 3. The status write only works when the status-arm opcode was the frame immediately before it. The hardware write-protect pin, combined with the lock bit, makes the lock one-way. The array engine reads the latch and status outputs. It raises a one-cycle strobe when it enters auto-increment programming.

Top module: `spi_wp_cmd_unit`

## Requirements
- R1: A frame whose first byte is 0x06 sets `wel` to 1. The change appears only after `cs_n` rises, and never while the frame is still open.
- R2: A frame whose first byte is 0x04 clears both `wel` and `aai` to 0 when `cs_n` rises. A one-cycle pulse on `aai_start` sets `aai` to 1.
- R3: A status write takes effect only if the frame just before it was exactly the single opcode 0x50. Any other frame in between, including another opcode, discards the arm.
- R4: A frame of opcode 0x01 followed by a data byte writes data bit 2 to `bp[0]`, data bit 3 to `bp[1]` and data bit 7 to `bpl`. All other data bits are ignored.
- R5: When `wp_n` is low and `bpl` is 1, the status write is ignored, and `bp` and `bpl` stay unchanged.
- R6: While `wp_n` is low and `bpl` is 0, a status write may set `bpl` to 1 and load `bp`. `bpl` can never go from 1 to 0 while `wp_n` is low.
- R7: With `wp_n` high, a single status write may set or clear `bpl` and change both `bp` bits at the same time.
- R8: The `wp_n` level used is the one present when `cs_n` rises at the end of the status-write frame. Its level earlier in the frame does not matter.
- R9: If `cs_n` rises before eight opcode bits, or before eight data bits of a status write, have been shifted in, no state changes and any pending arm is cleared.
- R10: Bits are shifted MSB first on SCK rising edges, in both SCK idle-low (mode 0) and idle-high (mode 3) framing. The bit count restarts whenever `cs_n` is high.
- R11: `so_oe` stays 0 at all times, including during every frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| si | input | 1 | SPI serial data in |
| wp_n | input | 1 | Hardware write-protect, active low |
| aai_start | input | 1 | One-cycle strobe from the array engine that sets the auto-increment flag |
| wel | output | 1 | Write-enable latch |
| aai | output | 1 | Auto-increment flag |
| bp | output | 2 | Block-protect bits |
| bpl | output | 1 | Protect-lock bit |
| so_oe | output | 1 | Serial-out driver enable, always deasserted |

## Verification
The assertions check on every cycle that the latch and the status bits move only in the cycle after a chip-select rise. They also check that a status change is always preceded by a live arm, that a locked status never moves while the protect pin is low, that the lock bit only falls with the pin high, and that the bit counter is idle while deselected. Only the bench scenarios can show the exact data-bit mapping, that an intervening frame discards the arm, that a late change of the protect pin decides the outcome, that short frames are dropped, and that mode 3 framing gives the same results as mode 0.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;

    localparam logic [7:0] OP_LATCH_SET = 8'h06;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_ARM  = 8'h50;
    localparam logic [7:0] OP_STAT_WR   = 8'h01;

    localparam int STAT_BP0_POS = 2;
    localparam int STAT_BP1_POS = 3;
    localparam int STAT_LCK_POS = 7;

    typedef enum logic [1:0] {
        IDX_OPCODE = 2'd0,
        IDX_DATA   = 2'd1,
        IDX_EXTRA  = 2'd2
    } byte_idx_e;

    typedef struct packed {
        logic       wel;
        logic       aai;
        logic [1:0] bp;
        logic       bpl;
        logic       armed;
    } prot_state_t;

    typedef struct packed {
        logic [7:0] opcode;
        logic [1:0] new_bp;
        logic       new_bpl;
        logic       got_op;
        logic       got_data;
    } frame_t;

endpackage

// File: rtl/spi_wp_sync.sv
module spi_wp_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic wp_n,
    output logic sck_rise,
    output logic cs_rise,
    output logic cs_active,
    output logic si_s,
    output logic wp_s
);

    localparam int NSIG = 4;
    localparam logic [NSIG-1:0] RST_VAL = 4'b1010; // {wp_n, si, cs_n, sck}

    typedef struct packed {
        logic [SYNC_STAGES-1:0][NSIG-1:0] chain;
        logic                             sck_prev;
        logic                             cs_prev;
    } sync_t;

    sync_t s_d, s_q;
    logic [NSIG-1:0] raw, last;

    assign raw  = {wp_n, si, cs_n, sck};
    assign last = s_q.chain[SYNC_STAGES-1];

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = raw;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.sck_prev = last[0];
        s_d.cs_prev  = last[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) begin
                s_q.chain[i] <= RST_VAL;
            end
            s_q.sck_prev <= 1'b0;
            s_q.cs_prev  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_active = !last[1];
    assign sck_rise  = last[0] && !s_q.sck_prev && !last[1];
    assign cs_rise   = last[1] && !s_q.cs_prev;
    assign si_s      = last[2];
    assign wp_s      = last[3];

endmodule

// File: rtl/spi_wp_shift.sv
module spi_wp_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              cs_active,
    input  logic              si_s,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_val,
    output logic [1:0]        byte_idx
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        idx;
        logic              vld;
        logic [BYTE_W-1:0] val;
        logic [1:0]        vidx;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (!cs_active) begin
            s_d.cnt = '0;
            s_d.idx = 2'd0;
        end else if (sck_rise) begin
            s_d.sh = {s_q.sh[BYTE_W-2:0], si_s};
            if (s_q.cnt == CNT_LAST) begin
                s_d.cnt  = '0;
                s_d.vld  = 1'b1;
                s_d.val  = {s_q.sh[BYTE_W-2:0], si_s};
                s_d.vidx = s_q.idx;
                if (s_q.idx != 2'd2) begin
                    s_d.idx = s_q.idx + 2'd1;
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign byte_vld = s_q.vld;
    assign byte_val = s_q.val;
    assign byte_idx = s_q.vidx;

    // R10: bit counter is idle after any deselected cycle
    p_cnt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (s_q.cnt == '0 && s_q.idx == 2'd0));

endmodule

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl
    import spi_wp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_val,
    input  logic [1:0] byte_idx,
    input  logic       cs_rise,
    input  logic       wp_s,
    input  logic       aai_start,
    output prot_state_t state
);

    prot_state_t st_d, st_q;
    frame_t      fr_d, fr_q;
    frame_t      fr_now;
    logic        locked;

    // frame content including a byte that lands in this very cycle
    always_comb begin
        fr_now = fr_q;
        if (byte_vld) begin
            if (byte_idx == IDX_OPCODE) begin
                fr_now.opcode = byte_val;
                fr_now.got_op = 1'b1;
            end else if (byte_idx == IDX_DATA) begin
                fr_now.new_bp   = {byte_val[STAT_BP1_POS], byte_val[STAT_BP0_POS]};
                fr_now.new_bpl  = byte_val[STAT_LCK_POS];
                fr_now.got_data = 1'b1;
            end
        end
    end

    assign locked = !wp_s && st_q.bpl;

    always_comb begin
        st_d = st_q;
        fr_d = fr_now;
        if (aai_start) begin
            st_d.aai = 1'b1;
        end
        if (cs_rise) begin
            fr_d       = '0;
            st_d.armed = 1'b0;
            if (fr_now.got_op) begin
                unique case (fr_now.opcode)
                    OP_LATCH_SET: st_d.wel = 1'b1;
                    OP_LATCH_CLR: begin
                        st_d.wel = 1'b0;
                        st_d.aai = 1'b0;
                    end
                    OP_STAT_ARM: st_d.armed = 1'b1;
                    OP_STAT_WR: begin
                        if (fr_now.got_data && st_q.armed && !locked) begin
                            st_d.bp = fr_now.new_bp;
                            if (wp_s) begin
                                st_d.bpl = fr_now.new_bpl;
                            end else begin
                                st_d.bpl = st_q.bpl | fr_now.new_bpl;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            fr_q <= '0;
        end else begin
            st_q <= st_d;
            fr_q <= fr_d;
        end
    end

    assign state = st_q;

    // R1: latch moves only right after a frame closes
    p_wel_at_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.wel) |-> $past(cs_rise));

    // R2: auto-increment flag is cleared only by a closing frame
    p_aai_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.aai) |-> $past(cs_rise));

    // R3: status only changes when an arm was pending at a frame close
    p_status_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ({st_q.bpl, st_q.bp} != $past({st_q.bpl, st_q.bp})) |-> ($past(st_q.armed) && $past(cs_rise)));

    // R5: locked status holds while the protect pin is low
    p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!wp_s) && $past(st_q.bpl)) |-> (st_q.bpl && $stable(st_q.bp)));

    // R6: lock bit only falls with the protect pin high
    p_bpl_oneway_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.bpl) |-> $past(wp_s));

endmodule

// File: rtl/spi_wp_cmd_unit.sv
module spi_wp_cmd_unit
    import spi_wp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    input  logic       wp_n,
    input  logic       aai_start,
    output logic       wel,
    output logic       aai,
    output logic [1:0] bp,
    output logic       bpl,
    output logic       so_oe
);

    logic              sck_rise, cs_rise, cs_active, si_s, wp_s;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_val;
    logic [1:0]        byte_idx;
    prot_state_t       state;

    spi_wp_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck),
        .cs_n      (cs_n),
        .si        (si),
        .wp_n      (wp_n),
        .sck_rise  (sck_rise),
        .cs_rise   (cs_rise),
        .cs_active (cs_active),
        .si_s      (si_s),
        .wp_s      (wp_s)
    );

    spi_wp_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .cs_active (cs_active),
        .si_s      (si_s),
        .byte_vld  (byte_vld),
        .byte_val  (byte_val),
        .byte_idx  (byte_idx)
    );

    spi_wp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_val  (byte_val[7:0]),
        .byte_idx  (byte_idx),
        .cs_rise   (cs_rise),
        .wp_s      (wp_s),
        .aai_start (aai_start),
        .state     (state)
    );

    assign wel   = state.wel;
    assign aai   = state.aai;
    assign bp    = state.bp;
    assign bpl   = state.bpl;
    // R11: write-type commands never drive serial out
    assign so_oe = 1'b0;

endmodule

// File: tb/sim_spi_wp_cmd_unit.sv
module sim_spi_wp_cmd_unit;

    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1, aai_start = 1'b0;
    logic wel, aai, bpl, so_oe;
    logic [1:0] bp;
    logic mode3 = 1'b0;
    int n_chk = 0, n_bad = 0, oe_bad = 0;

    always #2 clk = ~clk;

    spi_wp_cmd_unit u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
        .aai_start(aai_start), .wel(wel), .aai(aai), .bp(bp), .bpl(bpl), .so_oe(so_oe)
    );

    always @(negedge clk) if (so_oe) oe_bad++;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_frame();
        @(negedge clk);
        sck = mode3;
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic shift_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sck = 1'b0;
            si  = b[7-i];
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic close_frame();
        if (!mode3) sck = 1'b0;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic frame1(input logic [7:0] op);
        open_frame(); shift_bits(op, 8); close_frame();
    endtask

    task automatic frame2(input logic [7:0] op, input logic [7:0] d);
        open_frame(); shift_bits(op, 8); shift_bits(d, 8); close_frame();
    endtask

    task automatic stat_write(input logic [7:0] d);
        frame1(8'h50); frame2(8'h01, d);
    endtask

    function automatic logic [7:0] st();
        return {5'b0, bpl, bp};
    endfunction

    task automatic t_reset();
        check("R1 reset wel", {7'b0, wel}, 8'h00);
        check("R2 reset aai", {7'b0, aai}, 8'h00);
        check("R4 reset status", st(), 8'h00);
        check("R11 reset so_oe", {7'b0, so_oe}, 8'h00);
    endtask

    task automatic t_latch_set();
        open_frame(); shift_bits(8'h06, 8); wait_clk(12);
        check("R1 wel held while frame open", {7'b0, wel}, 8'h00);
        check("R11 so_oe during frame", {7'b0, so_oe}, 8'h00);
        close_frame();
        check("R1 wel after close", {7'b0, wel}, 8'h01);
    endtask

    task automatic t_latch_clr();
        @(negedge clk); aai_start = 1'b1; @(negedge clk); aai_start = 1'b0; wait_clk(2);
        check("R2 aai set by strobe", {7'b0, aai}, 8'h01);
        frame1(8'h04);
        check("R2 wel cleared", {7'b0, wel}, 8'h00);
        check("R2 aai cleared", {7'b0, aai}, 8'h00);
    endtask

    task automatic t_free_write();
        wp_n = 1'b1;
        stat_write(8'h8C);
        check("R7 set all three", st(), 8'h07);
        stat_write(8'h7B);
        check("R4 bit mapping 0x7B", st(), 8'h02);
    endtask

    task automatic t_arm_rule();
        frame2(8'h01, 8'h8C);
        check("R3 write without arm", st(), 8'h02);
        frame1(8'h50); frame1(8'h06); frame2(8'h01, 8'h8C);
        check("R3 arm discarded by other frame", st(), 8'h02);
        check("R1 intervening set took effect", {7'b0, wel}, 8'h01);
    endtask

    task automatic t_lock();
        wp_n = 1'b1;
        stat_write(8'h84);
        check("R7 lock with bp0", st(), 8'h05);
        wp_n = 1'b0;
        stat_write(8'h00);
        check("R5 locked write ignored", st(), 8'h05);
        stat_write(8'h88);
        check("R5 locked write ignored 2", st(), 8'h05);
    endtask

    task automatic t_late_wp();
        // pin low during frame, raised before close: write goes through
        wp_n = 1'b0;
        frame1(8'h50);
        open_frame(); shift_bits(8'h01, 8); shift_bits(8'h00, 8);
        wp_n = 1'b1; wait_clk(10);
        close_frame();
        check("R8 pin high at close unlocks", st(), 8'h00);
        wp_n = 1'b0;
        stat_write(8'h88);
        check("R6 lock under low pin", st(), 8'h06);
        // pin high during frame, lowered before close: ignored
        wp_n = 1'b1;
        frame1(8'h50);
        open_frame(); shift_bits(8'h01, 8); shift_bits(8'h00, 8);
        wp_n = 1'b0; wait_clk(10);
        close_frame();
        check("R8 pin low at close keeps lock", st(), 8'h06);
        wp_n = 1'b1;
    endtask

    task automatic t_abort();
        open_frame(); shift_bits(8'h04, 5); close_frame();
        check("R9 short opcode ignored", {7'b0, wel}, 8'h01);
        frame1(8'h50);
        open_frame(); shift_bits(8'h01, 8); shift_bits(8'h00, 4); close_frame();
        check("R9 short data ignored", st(), 8'h06);
        frame2(8'h01, 8'h00);
        check("R9 arm cleared by short frame", st(), 8'h06);
    endtask

    task automatic t_mode3();
        mode3 = 1'b1;
        frame1(8'h04);
        check("R10 mode3 clear", {7'b0, wel}, 8'h00);
        frame1(8'h06);
        check("R10 mode3 set", {7'b0, wel}, 8'h01);
        stat_write(8'h04);
        check("R10 mode3 status", st(), 8'h01);
        mode3 = 1'b0;
        sck = 1'b0;
        wait_clk(4);
    endtask

    initial begin : watchdog
        #600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_latch_set();
        t_latch_clr();
        t_free_write();
        t_arm_rule();
        t_lock();
        t_late_wp();
        t_abort();
        t_mode3();
        check("R11 so_oe never asserted", oe_bad[7:0], 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule